// File: doc/BRIEF.md
# Pseudorandom RAM Wiper

This block overwrites every word of a single-port RAM with pseudorandom data after a one-cycle start pulse. The data comes from a 32-bit Galois LFSR. The LFSR is loaded at start time from a seed, which is taken from part of the scrambling nonce that arrived with the latest key. Each LFSR state passes through a compile-time bit permutation before it is written.

While a wipe runs, the block drives a RAM write port at one word per cycle, with addresses rising in order. It also holds a busy signal high so that bus accesses are kept away from the RAM. When the last word has been written, a done flag is set.

The word counter is kept twice: once in true form and once inverted. The two copies are compared on every cycle. Any disagreement moves the block into a terminal error state. In that state writes stop, busy stays high and later start pulses are refused.

Top module: `ram_wiper`

## Requirements
- R1: After reset, ramReqO, initDoneO, initErrO and busyO are all 0.
- R2: Let startI be sampled high at a clock edge while the block is idle. From the next cycle on, ramReqO is high for exactly Depth = MemBytes/4 consecutive cycles, and ramAddrO is 0, 1, ..., Depth-1 in those cycles. With the default MemBytes of 4096, Depth is 1024.
- R3: Write k carries the permuted image of LFSR state L_k. L_0 is the seed sampled with the start pulse. L_{k+1} is L_k shifted right by one bit and, if bit 0 of L_k was 1, XORed with the tap mask 32'h80200003.
- R4: Bit j of ramDataO equals bit (j*PermStride + PermOffset) mod 32 of the LFSR state. The defaults are PermStride 13 and PermOffset 5. PermStride must be odd.
- R5: An all-zero seed is replaced by the compile-time seed DefaultSeed, whose default is 32'h5A17C3E9.
- R6: initDoneO goes to 1 in the cycle after the write to address Depth-1. It stays at 1 until the next accepted start pulse, which clears it at the same edge.
- R7: busyO is high in the cycle in which an accepted start pulse is presented. It stays high through the last write and is low in the cycle after the last write.
- R8: A start pulse that arrives while a wipe is running is ignored. Addresses carry on in sequence, and the data continues from the original seed.
- R9: If the two counter copies disagree, initErrO is set at the next edge and stays set. From then on ramReqO stays 0, busyO stays 1, initDoneO stays 0, and start pulses are ignored.
- R10: seedI is used only at the accepted start pulse. Changing it during a wipe does not affect the data written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startI | input | 1 | One-cycle request to begin a wipe |
| seedI | input | 32 | LFSR seed taken from the nonce |
| ramReqO | output | 1 | RAM write strobe |
| ramAddrO | output | AddrW | RAM word address |
| ramDataO | output | 32 | Pseudorandom write data |
| initDoneO | output | 1 | Wipe finished |
| initErrO | output | 1 | Terminal counter-mismatch error |
| busyO | output | 1 | Hold off bus accesses |

## Verification
The hardest situation to reach is a disagreement between the two counter copies, because no port sequence can produce one on a correct design. The bench brings it about by overriding the inverted copy with a hierarchical force in the middle of a wipe, at about address 50. Once the error is raised, it checks that writes stop, that busy stays high and that a later start pulse is refused. A second hard-to-reach case is a start pulse that lands inside a running wipe while the seed input also changes. The bench drives both at once and relies on the scoreboard to show that the data still follows the first seed without any gap.

// File: rtl/wipe_pkg.sv
package wipe_pkg;

  localparam int WordBits = 32;

  typedef logic [WordBits-1:0] wordT;

  // Control-to-datapath strobes
  typedef struct packed {
    logic load;   // take a fresh seed
    logic step;   // advance one state
  } wipeStrobeT;

  typedef enum logic [1:0] {
    StIdle  = 2'b00,
    StRun   = 2'b01,
    StFault = 2'b10
  } wipeStateT;

  // Right-shifting Galois step
  function automatic wordT lfsrAdvance(input wordT cur, input wordT taps);
    wordT nxt;
    nxt = cur >> 1;
    if (cur[0]) nxt = nxt ^ taps;
    return nxt;
  endfunction

endpackage

// File: rtl/wipe_ctrl.sv
module wipe_ctrl
  import wipe_pkg::*;
#(
  parameter int Depth = 1024,
  parameter int AddrW = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startI,
  output wipeStrobeT       strobeO,
  output logic             ramReqO,
  output logic [AddrW-1:0] ramAddrO,
  output logic             initDoneO,
  output logic             initErrO,
  output logic             busyO
);

  localparam logic [AddrW-1:0] LastAddr = AddrW'(Depth - 1);

  wipeStateT        state;
  logic [AddrW-1:0] cntMain;
  logic [AddrW-1:0] cntShadow;   // stored inverted
  logic             doneQ;
  logic             mismatch;
  logic             accept;

  assign mismatch = (cntMain != ~cntShadow);
  assign accept   = startI && (state == StIdle) && !mismatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= StIdle;
      cntMain   <= '0;
      cntShadow <= '1;
      doneQ     <= 1'b0;
    end else begin
      unique case (state)
        StIdle: begin
          if (mismatch) begin
            state <= StFault;
            doneQ <= 1'b0;
          end else if (startI) begin
            state     <= StRun;
            cntMain   <= '0;
            cntShadow <= '1;
            doneQ     <= 1'b0;
          end
        end
        StRun: begin
          if (mismatch) begin
            state <= StFault;
          end else if (cntMain == LastAddr) begin
            state <= StIdle;
            doneQ <= 1'b1;
          end else begin
            cntMain   <= cntMain + 1'b1;
            cntShadow <= cntShadow - 1'b1;
          end
        end
        default: begin
          state <= StFault;
          doneQ <= 1'b0;
        end
      endcase
    end
  end

  always_comb begin
    strobeO.load = accept;
    strobeO.step = (state == StRun);
  end

  assign ramReqO   = (state == StRun);
  assign ramAddrO  = cntMain;
  assign initDoneO = doneQ;
  assign initErrO  = (state == StFault);
  assign busyO     = (state != StIdle) || accept;

endmodule

// File: rtl/wipe_datapath.sv
module wipe_datapath
  import wipe_pkg::*;
#(
  parameter logic [31:0] DefaultSeed = 32'h5A17C3E9,
  parameter logic [31:0] LfsrTaps    = 32'h80200003,
  parameter int          PermStride  = 13,   // odd, so the map is a bijection
  parameter int          PermOffset  = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  wipeStrobeT strobeI,
  input  wordT       seedI,
  output wordT       dataO
);

  wordT lfsrQ;
  wordT seedEff;

  assign seedEff = (seedI == '0) ? wordT'(DefaultSeed) : seedI;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsrQ <= wordT'(DefaultSeed);
    end else if (strobeI.load) begin
      lfsrQ <= seedEff;
    end else if (strobeI.step) begin
      lfsrQ <= lfsrAdvance(lfsrQ, wordT'(LfsrTaps));
    end
  end

  for (genvar j = 0; j < WordBits; j++) begin : g_perm
    localparam int SrcBit = (j * PermStride + PermOffset) % WordBits;
    assign dataO[j] = lfsrQ[SrcBit];
  end

endmodule

// File: rtl/ram_wiper.sv
module ram_wiper
  import wipe_pkg::*;
#(
  parameter int          MemBytes    = 4096,
  parameter logic [31:0] DefaultSeed = 32'h5A17C3E9,
  parameter logic [31:0] LfsrTaps    = 32'h80200003,
  parameter int          PermStride  = 13,
  parameter int          PermOffset  = 5,
  localparam int         Depth       = MemBytes / (WordBits / 8),
  localparam int         AddrW       = (Depth > 1) ? $clog2(Depth) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startI,
  input  logic [31:0]      seedI,
  output logic             ramReqO,
  output logic [AddrW-1:0] ramAddrO,
  output logic [31:0]      ramDataO,
  output logic             initDoneO,
  output logic             initErrO,
  output logic             busyO
);

  wipeStrobeT strobe;

  wipe_ctrl #(
    .Depth (Depth),
    .AddrW (AddrW)
  ) ctrlInst (
    .clk       (clk),
    .rstN      (rstN),
    .startI    (startI),
    .strobeO   (strobe),
    .ramReqO   (ramReqO),
    .ramAddrO  (ramAddrO),
    .initDoneO (initDoneO),
    .initErrO  (initErrO),
    .busyO     (busyO)
  );

  wipe_datapath #(
    .DefaultSeed (DefaultSeed),
    .LfsrTaps    (LfsrTaps),
    .PermStride  (PermStride),
    .PermOffset  (PermOffset)
  ) dpInst (
    .clk     (clk),
    .rstN    (rstN),
    .strobeI (strobe),
    .seedI   (seedI),
    .dataO   (ramDataO)
  );

endmodule

// File: rtl/wipe_checker.sv
module wipe_checker #(
  parameter int Depth = 1024,
  parameter int AddrW = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             startI,
  input logic             ramReqO,
  input logic [AddrW-1:0] ramAddrO,
  input logic             initDoneO,
  input logic             initErrO,
  input logic             busyO
);

  localparam logic [AddrW-1:0] LastAddr = AddrW'(Depth - 1);

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramReqO && $past(ramReqO) |-> ramAddrO == AddrW'($past(ramAddrO) + 1'b1));

  // R7
  req_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramReqO |-> busyO);

  // R6
  done_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initDoneO) |-> $past(ramReqO) && $past(ramAddrO) == LastAddr);

  // R8
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramReqO && startI |=> !(ramReqO && ramAddrO == '0));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    initErrO |=> initErrO);

  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    initErrO |-> !ramReqO && busyO && !initDoneO);

endmodule

bind ram_wiper wipe_checker #(
  .Depth (Depth),
  .AddrW (AddrW)
) chkInst (
  .clk       (clk),
  .rstN      (rstN),
  .startI    (startI),
  .ramReqO   (ramReqO),
  .ramAddrO  (ramAddrO),
  .initDoneO (initDoneO),
  .initErrO  (initErrO),
  .busyO     (busyO)
);

// File: tb/ram_wiper_tb_top.sv
module ram_wiper_tb_top;

  localparam int          MemBytes = 4096;
  localparam int          Depth    = MemBytes / 4;
  localparam int          AddrW    = $clog2(Depth);
  localparam logic [31:0] DefSeed  = 32'h5A17C3E9;
  localparam logic [31:0] Taps     = 32'h80200003;
  localparam int          Stride   = 13;
  localparam int          Offset   = 5;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startI = 1'b0;
  logic [31:0]      seedI = '0;
  logic             ramReqO;
  logic [AddrW-1:0] ramAddrO;
  logic [31:0]      ramDataO;
  logic             initDoneO;
  logic             initErrO;
  logic             busyO;

  int vectors = 0;
  int fails = 0;

  always #4 clk = ~clk;

  ram_wiper #(
    .MemBytes    (MemBytes),
    .DefaultSeed (DefSeed),
    .LfsrTaps    (Taps),
    .PermStride  (Stride),
    .PermOffset  (Offset)
  ) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .startI    (startI),
    .seedI     (seedI),
    .ramReqO   (ramReqO),
    .ramAddrO  (ramAddrO),
    .ramDataO  (ramDataO),
    .initDoneO (initDoneO),
    .initErrO  (initErrO),
    .busyO     (busyO)
  );

  typedef struct {
    logic [AddrW-1:0] addr;
    logic [31:0]      data;
  } itemT;

  itemT        expQ[$];
  logic [31:0] mem [Depth];

  function automatic logic [31:0] stepRef(input logic [31:0] s);
    logic [31:0] n;
    n = {1'b0, s[31:1]};
    if (s[0]) n = n ^ Taps;
    return n;
  endfunction

  function automatic logic [31:0] permRef(input logic [31:0] s);
    logic [31:0] o;
    for (int j = 0; j < 32; j++) o[j] = s[(j * Stride + Offset) % 32];
    return o;
  endfunction

  function automatic logic [31:0] wordRef(input logic [31:0] seed, input int k);
    logic [31:0] s;
    s = (seed == '0) ? DefSeed : seed;
    for (int i = 0; i < k; i++) s = stepRef(s);
    return permRef(s);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver side of the scoreboard
  task automatic pushRun(input logic [31:0] seed);
    logic [31:0] s;
    s = (seed == '0) ? DefSeed : seed;
    for (int k = 0; k < Depth; k++) begin
      itemT it;
      it.addr = AddrW'(k);
      it.data = permRef(s);
      expQ.push_back(it);
      s = stepRef(s);
    end
  endtask

  // Monitor side
  always @(negedge clk) begin
    if (rstN && ramReqO) begin
      if (expQ.size() == 0) begin
        check("R9 unexpected write", 32'(ramReqO), 32'h0);
      end else begin
        itemT it;
        it = expQ.pop_front();
        check("R2 address", 32'(ramAddrO), 32'(it.addr));
        check("R3 R4 data", ramDataO, it.data);
        mem[ramAddrO] = ramDataO;
      end
    end
  end

  // Runs a wipe; optionally pulses start and alters the seed at cycle midAt
  task automatic runWipe(input logic [31:0] seed, input int midAt, input logic [31:0] midSeed);
    @(negedge clk);
    startI = 1'b1;
    seedI  = seed;
    pushRun(seed);
    #1;
    check("R7 busy on start cycle", 32'(busyO), 32'h1);
    @(negedge clk);
    startI = 1'b0;
    for (int c = 0; c < Depth; c++) begin
      if (c > 0) @(negedge clk);
      if (c == 0) check("R6 done cleared by start", 32'(initDoneO), 32'h0);
      if (busyO !== 1'b1) check("R7 busy during wipe", 32'(busyO), 32'h1);
      if (c == midAt) begin
        startI = 1'b1;
        seedI  = midSeed;   // R8 R10
      end else if (c == midAt + 1) begin
        startI = 1'b0;
      end
    end
    @(negedge clk);
    check("R6 done after last write", 32'(initDoneO), 32'h1);
    check("R7 busy low after wipe", 32'(busyO), 32'h0);
    check("R2 write count", 32'(expQ.size()), 32'h0);
    check("R2 first word", mem[0], wordRef(seed, 0));
    check("R2 last word", mem[Depth-1], wordRef(seed, Depth - 1));
    repeat (3) @(negedge clk);
    check("R6 done holds", 32'(initDoneO), 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 req", 32'(ramReqO), 32'h0);
    check("R1 done", 32'(initDoneO), 32'h0);
    check("R1 err", 32'(initErrO), 32'h0);
    check("R1 busy", 32'(busyO), 32'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", 32'(ramReqO), 32'h0);

    runWipe(32'h1234_5678, -5, '0);                 // R2 R3 R4
    runWipe(32'hDEAD_BEEF, 100, 32'h0BAD_F00D);     // R8 R10
    runWipe(32'h0000_0000, -5, '0);                 // R5
    runWipe(32'h8000_0001, 500, 32'h0000_0000);     // R8 R10

    // R9: corrupt the inverted counter copy mid-wipe
    @(negedge clk);
    startI = 1'b1;
    seedI  = 32'hCAFE_0042;
    pushRun(32'hCAFE_0042);
    @(negedge clk);
    startI = 1'b0;
    repeat (50) @(negedge clk);
    force dut_i.ctrlInst.cntShadow = '0;
    @(posedge clk);
    #1;
    release dut_i.ctrlInst.cntShadow;
    expQ.delete();
    @(negedge clk);
    check("R9 err set", 32'(initErrO), 32'h1);
    check("R9 writes stop", 32'(ramReqO), 32'h0);
    check("R9 busy held", 32'(busyO), 32'h1);
    check("R9 done low", 32'(initDoneO), 32'h0);
    startI = 1'b1;
    seedI  = 32'h1111_2222;
    @(negedge clk);
    startI = 1'b0;
    repeat (20) @(negedge clk);
    check("R9 err sticky", 32'(initErrO), 32'h1);
    check("R9 restart refused", 32'(ramReqO), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule